// File: doc/BRIEF.md
# Iterative Signed/Unsigned Integer Divider

This block divides one unsigned magnitude by another over several clock cycles. It retires one quotient bit per cycle with a restoring shift-and-subtract loop. The caller supplies the dividend and divisor magnitudes already stripped of sign. Four mode flags select the behaviour: signed range checking, half-width (W/2-bit) operation, the extended form, and the remainder form. A separate negate flag asks the divider to return the two's complement of its answer. The caller derives that flag from the operand signs: the dividend sign alone for a remainder, or the dividend sign XOR the divisor sign for a quotient.

The unit takes a one-cycle start pulse and latches the operands and flags. After the iterations it raises a one-cycle done strobe together with the W-bit result and an overflow bit. A zero divisor gives overflow with a zero result. So does a quotient that does not fit the operand width, or a signed quotient outside the two's-complement range. The result and overflow outputs hold their value until the next operation completes.

Top module: `div_unit`

## Requirements
- R1: After reset is released, done, busy, overflow and result are all zero.
- R2: In full-width quotient form (half_width=0, extended=0, modulus=0, negate=0), a non-zero divisor gives result = floor(dividend / divisor) and overflow = 0.
- R3: With modulus=1 the result is the remainder of the same division instead of the quotient. The remainder form never reports a signed-range overflow.
- R4: With half_width=1, the upper W/2 bits of divisor are ignored and extended has no effect. The whole W-bit dividend is divided by the low-half divisor. A quotient of 2^(W/2) or more gives overflow. The answer occupies result[W/2-1:0]. result[W-1:W/2] is the copy of bit W/2-1 when is_signed=1, and zero otherwise.
- R5: With half_width=0 and extended=1, the dividend is dividend × 2^W (the dividend followed by W zero bits). Overflow is reported exactly when dividend >= divisor.
- R6: A divisor of zero (in the width in use) gives overflow = 1 and result = 0 in every form.
- R7: With negate=1 the result is the two's complement, within the operand width N (W or W/2), of the unsigned quotient or remainder.
- R8: With is_signed=1 and modulus=0, overflow = 1 and result = 0 in two cases. With negate=0 the case is a quotient magnitude >= 2^(N-1). With negate=1 the case is a quotient magnitude > 2^(N-1).
- R9: done is high for exactly one cycle. It rises N+1 clock edges after the edge that sampled start, where N is W in full-width mode and W/2 in half-width mode. busy is high from the edge after start until done rises.
- R10: A start pulse while busy is high is ignored. The running operation completes with its own result and timing, and no extra done strobe follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | One-cycle request to begin a division |
| dividend | input | W | Dividend magnitude (pre-shifted by caller for half-width extended) |
| divisor | input | W | Divisor magnitude |
| is_signed | input | 1 | Apply signed range check and sign-extend half-width results |
| half_width | input | 1 | Operate on W/2-bit operands |
| extended | input | 1 | Full-width extended form: dividend followed by W zeros |
| modulus | input | 1 | Return remainder instead of quotient |
| negate | input | 1 | Return two's complement of the answer |
| busy | output | 1 | Division in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | W | Quotient or remainder |
| overflow | output | 1 | Result does not fit or divisor is zero |

## Verification
A corrupted partial remainder or quotient shift register does not show up until done. There it gives a wrong result for that single operation, N+1 cycles after start, and later operations are unaffected. A wrong iteration count or a lost busy flag shows up as a done strobe arriving early, late or twice. The bench measures that latency on every operation. Wrong pre-check or range logic shows up as an overflow flag that disagrees with an arithmetic model. The sweeps compare against that model across all forms and every low-half divisor.

// File: rtl/div_pkg.sv
package div_pkg;
  typedef struct packed {
    logic sgn;
    logic half;
    logic modu;
    logic neg;
  } div_mode_t;
endpackage

// File: rtl/div_prep.sv
module div_prep #(
  parameter int W = 64
) (
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         half,
  input  logic         ext,
  output logic [W-1:0] rem_init,
  output logic [W-1:0] dq_init,
  output logic [W-1:0] dsr_eff,
  output logic         pre_ovf
);
  localparam int H = W / 2;

  always_comb begin
    if (half) begin
      dsr_eff  = {{H{1'b0}}, divisor[H-1:0]};
      rem_init = {{H{1'b0}}, dividend[W-1:H]};
      dq_init  = {dividend[H-1:0], {H{1'b0}}};
    end else begin
      dsr_eff  = divisor;
      rem_init = ext ? dividend : '0;
      dq_init  = ext ? '0 : dividend;
    end
    // partial remainder already at or above divisor: quotient cannot fit
    pre_ovf = (rem_init >= dsr_eff);
  end
endmodule

// File: rtl/div_step.sv
module div_step #(
  parameter int W = 64
) (
  input  logic [W-1:0] rem_in,
  input  logic [W-1:0] dq_in,
  input  logic [W-1:0] dsr,
  output logic [W-1:0] rem_out,
  output logic [W-1:0] dq_out
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    trial   = {rem_in, dq_in[W-1]};
    diff    = trial - {1'b0, dsr};
    fits    = (trial >= {1'b0, dsr});
    rem_out = fits ? diff[W-1:0] : trial[W-1:0];
    dq_out  = {dq_in[W-2:0], fits};
  end
endmodule

// File: rtl/div_post.sv
module div_post
  import div_pkg::*;
#(
  parameter int W = 64
) (
  input  logic [W-1:0] rem,
  input  logic [W-1:0] dq,
  input  div_mode_t    mode,
  input  logic         pre_ovf,
  output logic [W-1:0] result,
  output logic         ovf
);
  localparam int H = W / 2;

  logic [H-1:0] mag_h;
  logic [H-1:0] val_h;
  logic [W-1:0] mag_f;
  logic [W-1:0] val_f;
  logic         sovf;

  always_comb begin
    mag_h = mode.modu ? rem[H-1:0] : dq[H-1:0];
    mag_f = mode.modu ? rem : dq;
    val_h = mode.neg ? (H'(0) - mag_h) : mag_h;
    val_f = mode.neg ? (W'(0) - mag_f) : mag_f;
    if (mode.half) begin
      sovf   = !mode.modu && mode.sgn && mag_h[H-1] && (!mode.neg || (|mag_h[H-2:0]));
      result = {(mode.sgn ? {H{val_h[H-1]}} : {H{1'b0}}), val_h};
    end else begin
      sovf   = !mode.modu && mode.sgn && mag_f[W-1] && (!mode.neg || (|mag_f[W-2:0]));
      result = val_f;
    end
    ovf = pre_ovf || sovf;
    if (ovf) begin
      result = '0;
    end
  end
endmodule

// File: rtl/div_unit.sv
module div_unit
  import div_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  input  logic         is_signed,
  input  logic         half_width,
  input  logic         extended,
  input  logic         modulus,
  input  logic         negate,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result,
  output logic         overflow
);
  localparam int H  = W / 2;
  localparam int CW = $clog2(W + 1);

  // reset synchronizer: asserts asynchronously, releases on clk
  logic [1:0] rsync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign arst_n = rsync_q[1];

  logic          busy_q, busy_d;
  logic          done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [W-1:0]  rem_q, rem_d;
  logic [W-1:0]  dq_q, dq_d;
  logic [W-1:0]  dsr_q, dsr_d;
  div_mode_t     mode_q, mode_d;
  logic          povf_q, povf_d;
  logic [W-1:0]  res_q, res_d;
  logic          ovf_q, ovf_d;

  logic          ld_en, step_en, fin_en;

  logic [W-1:0]  rem_init, dq_init, dsr_eff;
  logic          pre_ovf;
  logic [W-1:0]  rem_nx, dq_nx;
  logic [W-1:0]  post_res;
  logic          post_ovf;

  div_prep #(.W(W)) u_prep (
    .dividend (dividend),
    .divisor  (divisor),
    .half     (half_width),
    .ext      (extended),
    .rem_init (rem_init),
    .dq_init  (dq_init),
    .dsr_eff  (dsr_eff),
    .pre_ovf  (pre_ovf)
  );

  div_step #(.W(W)) u_step (
    .rem_in  (rem_q),
    .dq_in   (dq_q),
    .dsr     (dsr_q),
    .rem_out (rem_nx),
    .dq_out  (dq_nx)
  );

  div_post #(.W(W)) u_post (
    .rem     (rem_q),
    .dq      (dq_q),
    .mode    (mode_q),
    .pre_ovf (povf_q),
    .result  (post_res),
    .ovf     (post_ovf)
  );

  // next-state
  always_comb begin
    ld_en   = !busy_q && start;
    step_en = busy_q && (cnt_q != '0);
    fin_en  = busy_q && (cnt_q == '0);

    busy_d = busy_q;
    done_d = 1'b0;
    cnt_d  = cnt_q;
    rem_d  = rem_q;
    dq_d   = dq_q;
    dsr_d  = dsr_q;
    mode_d = mode_q;
    povf_d = povf_q;
    res_d  = res_q;
    ovf_d  = ovf_q;

    if (ld_en) begin
      busy_d = 1'b1;
      cnt_d  = half_width ? CW'(H) : CW'(W);
      rem_d  = rem_init;
      dq_d   = dq_init;
      dsr_d  = dsr_eff;
      povf_d = pre_ovf;
      mode_d = '{sgn: is_signed, half: half_width, modu: modulus, neg: negate};
    end else if (step_en) begin
      cnt_d = cnt_q - CW'(1);
      rem_d = rem_nx;
      dq_d  = dq_nx;
    end else if (fin_en) begin
      busy_d = 1'b0;
      done_d = 1'b1;
      res_d  = post_res;
      ovf_d  = post_ovf;
    end
  end

  // control registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      cnt_q  <= cnt_d;
    end
  end

  // datapath registers, enabled on load or iteration
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      rem_q  <= '0;
      dq_q   <= '0;
      dsr_q  <= '0;
      mode_q <= '0;
      povf_q <= 1'b0;
    end else if (ld_en || step_en) begin
      rem_q  <= rem_d;
      dq_q   <= dq_d;
      dsr_q  <= dsr_d;
      mode_q <= mode_d;
      povf_q <= povf_d;
    end
  end

  // result registers, enabled on completion
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      res_q <= '0;
      ovf_q <= 1'b0;
    end else if (fin_en) begin
      res_q <= res_d;
      ovf_q <= ovf_d;
    end
  end

  assign busy     = busy_q;
  assign done     = done_q;
  assign result   = res_q;
  assign overflow = ovf_q;

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |=> !done_q); // R9
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!arst_n)
    done_q |-> !busy_q); // R9
  AST_OVF_ZERO_RESULT: assert property (@(posedge clk) disable iff (!arst_n)
    (done_q && ovf_q) |-> (res_q == '0)); // R6
  AST_REM_BELOW_DIVISOR: assert property (@(posedge clk) disable iff (!arst_n)
    (busy_q && !povf_q) |-> (rem_q < dsr_q)); // R2
  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (!arst_n)
    (busy_q && start && (cnt_q != '0)) |=> (busy_q && $stable(dsr_q) && $stable(mode_q))); // R10
  AST_HALF_UPPER_ZERO: assert property (@(posedge clk) disable iff (!arst_n)
    (done_q && mode_q.half && !mode_q.sgn) |-> (res_q[W-1:H] == '0)); // R4
endmodule

// File: tb/div_unit_bench.sv
module div_unit_bench;
  localparam int W = 8;
  localparam int H = W / 2;

  logic         clk;
  logic         rst_n;
  logic         start;
  logic [W-1:0] dividend;
  logic [W-1:0] divisor;
  logic         is_signed, half_width, extended, modulus, negate;
  logic         busy, done, overflow;
  logic [W-1:0] result;

  int checks;
  int fails;
  int cyc;

  div_unit #(.W(W)) u_div_unit (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .dividend   (dividend),
    .divisor    (divisor),
    .is_signed  (is_signed),
    .half_width (half_width),
    .extended   (extended),
    .modulus    (modulus),
    .negate     (negate),
    .busy       (busy),
    .done       (done),
    .result     (result),
    .overflow   (overflow)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 190000) begin
        checks++;
        fails++;
        $display("FAIL watchdog R9: actual cycles %0d expected below 190000", cyc);
        finish_run();
      end
    end
  end

  // arithmetic model: returns {ovf, result}
  function automatic logic [W:0] model(int a, int d, bit sgn, bit half, bit ext, bit md, bit ng);
    int  n   = half ? H : W;
    int  lim = 1 << n;
    int  dv  = half ? (d % (1 << H)) : d;
    int  dd  = (half || !ext) ? a : a * (1 << W);
    int  q, r, mag, val;
    bit  ov;
    ov = 1'b0;
    q = 0;
    r = 0;
    if (dv == 0) ov = 1'b1;
    else begin
      q = dd / dv;
      r = dd % dv;
      if (q >= lim) ov = 1'b1;
      else if (!md && sgn && (ng ? (q > lim / 2) : (q >= lim / 2))) ov = 1'b1;
    end
    if (ov) return {1'b1, {W{1'b0}}};
    mag = md ? r : q;
    val = ng ? ((lim - mag) % lim) : mag;
    if (half && sgn && val >= lim / 2) val = val + ((1 << W) - lim);
    return {1'b0, W'(val)};
  endfunction

  function automatic string tag_of(int d, bit sgn, bit half, bit ext, bit md, bit ng, bit ov);
    int dv = half ? (d % (1 << H)) : d;
    if (dv == 0) return "R6";
    if (ov && sgn && !md) return "R8";
    if (half) return "R4";
    if (ext) return "R5";
    if (ng) return "R7";
    if (md) return "R3";
    return "R2";
  endfunction

  task automatic run_op(int a, int d, bit sgn, bit half, bit ext, bit md, bit ng, bit poke);
    logic [W:0] exp_v;
    int  lat;
    int  n = half ? H : W;
    string tg;
    @(negedge clk);
    dividend   = W'(a);
    divisor    = W'(d);
    is_signed  = sgn;
    half_width = half;
    extended   = ext;
    modulus    = md;
    negate     = ng;
    start      = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 40) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
      if (poke && lat == 2) begin
        // R10: a second request with other operands while busy
        dividend  = W'(a + 17);
        divisor   = W'(d + 3);
        modulus   = !md;
        start     = 1'b1;
      end else begin
        start = 1'b0;
      end
    end
    start = 1'b0;
    exp_v = model(a, d, sgn, half, ext, md, ng);
    tg = poke ? "R10" : tag_of(d, sgn, half, ext, md, ng, exp_v[W]);
    checks++;
    if ({overflow, result} !== exp_v) begin
      fails++;
      $display("FAIL %s a=%0d d=%0d s%0d h%0d e%0d m%0d n%0d: actual ovf=%0b res=%0h expected ovf=%0b res=%0h",
               tg, a, d, sgn, half, ext, md, ng, overflow, result, exp_v[W], exp_v[W-1:0]);
    end
    checks++;
    if (lat != n + 1) begin
      fails++;
      $display("FAIL R9 latency: actual %0d expected %0d", lat, n + 1);
    end
    if (poke) begin
      // R10: no second completion from the ignored request
      for (int k = 0; k < n + 3; k++) begin
        @(negedge clk);
        checks++;
        if (done !== 1'b0 || busy !== 1'b0) begin
          fails++;
          $display("FAIL R10 extra activity: actual done=%0b busy=%0b expected 0 0", done, busy);
        end
      end
    end
  endtask

  int dlist [12] = '{0, 1, 2, 3, 5, 7, 13, 64, 127, 128, 200, 255};

  initial begin
    checks = 0;
    fails = 0;
    rst_n = 1'b0;
    start = 1'b0;
    dividend = '0;
    divisor = '0;
    is_signed = 1'b0;
    half_width = 1'b0;
    extended = 1'b0;
    modulus = 1'b0;
    negate = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (done !== 1'b0 || busy !== 1'b0 || overflow !== 1'b0 || result !== '0) begin
      fails++;
      $display("FAIL R1 reset: actual done=%0b busy=%0b ovf=%0b res=%0h expected 0 0 0 0",
               done, busy, overflow, result);
    end

    // directed corner cases
    run_op(200, 7, 0, 0, 0, 0, 0, 0);    // R2
    run_op(200, 7, 0, 0, 0, 1, 0, 0);    // R3
    run_op(100, 0, 1, 0, 1, 1, 1, 0);    // R6
    run_op(6, 7, 0, 0, 1, 0, 0, 0);      // R5 fits
    run_op(7, 7, 0, 0, 1, 0, 0, 0);      // R5 overflow
    run_op(128, 1, 1, 0, 0, 0, 1, 0);    // R8 most negative fits
    run_op(128, 1, 1, 0, 0, 0, 0, 0);    // R8 overflow
    run_op(8, 1, 1, 1, 0, 0, 1, 0);      // R4/R8 half most negative
    run_op(30, 4, 0, 0, 0, 0, 1, 0);     // R7
    run_op(150, 9, 0, 0, 0, 0, 0, 1);    // R10
    run_op(9, 240, 1, 1, 1, 1, 1, 1);    // R10 half

    // half-width sweep: every dividend, every low-half divisor
    for (int a = 0; a < 256; a++) begin
      for (int dl = 0; dl < 16; dl++) begin
        int k = a + dl;
        int d = (((a * 7 + dl * 3) % 16) * 16) + dl;
        run_op(a, d, k[0], 1'b1, k[3], k[1], k[2], 1'b0);
      end
    end

    // full-width sweep
    for (int a = 0; a < 256; a++) begin
      for (int j = 0; j < 12; j++) begin
        int k = a * 5 + j;
        run_op(a, dlist[j], k[0], 1'b0, k[3], k[1], k[2], 1'b0);
      end
    end

    finish_run();
  end
endmodule